// File: doc/BRIEF.md
# Exception Entry Sequencer

This block holds the exception-related control registers of a small 32-bit soft processor and performs the register side of exception entry. When the core raises a synchronous exception, it pulses a strobe together with a 5-bit cause code. An external interrupt arrives as a level request. On the following clock edge the block updates several registers together: the status word, the saved-status copies, the cause register, the memory-management status word, the two return-address registers and the program counter.

A handler-active flag in the status word sets how deeply the block saves context. A translation miss taken while that flag is clear is a fast miss. It saves context and is redirected to a dedicated vector. A miss taken while the flag is already set is a double miss. It keeps the saved context and goes to the general vector. Software-style exceptions and breakpoints that nest inside a handler also leave the saved context alone.

The core's control-register write path loads the status-family registers. While an exception is being entered, that write is dropped. Each register's next value is also available as an output.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Status bit positions are PIE=bit0, U=bit1, EH=bit2 and IH=bit3. Every accepted entry clears PIE and U. A synchronous entry sets EH and an interrupt entry sets IH. All other status bits keep their values.
- R2: An accepted entry writes its cause code into bits 6:2 of the cause register, and all other bits of that register keep their values. An interrupt entry writes code 2.
- R3: An interrupt is accepted only when irq_i is high, status PIE is set and exc_req_i is low. On acceptance, estatus takes the old status, ea takes pc_i+4 and pc jumps to gen_vec_i.
- R4: A translation miss (code 12) with EH clear copies status to estatus, clears mmu-status bit1 (double flag), sets mmu-status bit0 (write-enable flag), loads ea with pc_i+4 and jumps to miss_vec_i.
- R5: A translation miss with EH set leaves estatus and ea unchanged, sets mmu-status bit1 and jumps to gen_vec_i.
- R6: A read, write or execute permission fault (codes 13, 14, 15) always copies status to estatus, loads ea with pc_i+4 and jumps to gen_vec_i.
- R7: Trap (3), illegal instruction (5), supervisor-only instruction (9) and supervisor-only data (11) copy status to estatus and load ea with pc_i+4 only when EH was clear. They always jump to gen_vec_i.
- R8: A breakpoint (code 7) saves status to bstatus and pc_i+4 to ba only when EH was clear. It never touches estatus or ea, and it jumps to gen_vec_i.
- R9: When exc_req_i and irq_i are both high, the synchronous exception is taken and the interrupt is not.
- R10: A strobe carrying any code other than 3, 5, 7, 9, 11, 12, 13, 14 or 15 raises abort_o for one cycle after the edge and changes no register. No interrupt is taken in that cycle.
- R11: ctl_wr_i with ctl_sel_i values 0 (status), 1 (estatus), 2 (bstatus), 3 (cause) or 4 (mmu-status) loads ctl_wdata_i on the next edge. The write is dropped whenever exc_req_i is high or an interrupt is accepted.
- R12: Every register changes on the single edge that follows the strobe, to the value its *_nx output showed before that edge. Reset clears all registers and abort_o to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req_i | input | 1 | One-cycle synchronous exception strobe |
| cause_i | input | 5 | Cause code for the strobe |
| irq_i | input | 1 | External interrupt request level |
| pc_i | input | 32 | Address of the faulting instruction |
| gen_vec_i | input | 32 | General exception vector |
| miss_vec_i | input | 32 | Fast translation-miss vector |
| ctl_wr_i | input | 1 | Control-register write strobe |
| ctl_sel_i | input | 3 | Control-register select |
| ctl_wdata_i | input | 32 | Control-register write data |
| status_nx | output | 32 | Next status |
| estatus_nx | output | 32 | Next exception saved status |
| bstatus_nx | output | 32 | Next breakpoint saved status |
| cause_nx | output | 32 | Next cause register |
| mmust_nx | output | 32 | Next mmu-status word |
| ea_nx | output | 32 | Next exception return address |
| ba_nx | output | 32 | Next breakpoint return address |
| pc_nx | output | 32 | Next program counter |
| status_q | output | 32 | Status register |
| estatus_q | output | 32 | Exception saved status |
| bstatus_q | output | 32 | Breakpoint saved status |
| cause_q | output | 32 | Cause register |
| mmust_q | output | 32 | Mmu-status register |
| ea_q | output | 32 | Exception return address |
| ba_q | output | 32 | Breakpoint return address |
| pc_q | output | 32 | Program counter |
| abort_o | output | 1 | Unrecognised cause seen on the previous edge |

## Verification
Two pairs of events can land in the same cycle. A synchronous strobe can arrive together with a pending interrupt, and a control-register write can coincide with an entry. The sweep covers every cause code with the EH, PIE and irq_i combinations. In each strobe cycle it also issues a write to estatus with a recognisable value. The outcome is judged from the cause field, the status flag that was set (EH or IH) and whether estatus holds the write data. Interrupt-only cycles with PIE clear show the write landing and no entry occurring.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int STS_PIE = 0;
  localparam int STS_U   = 1;
  localparam int STS_EH  = 2;
  localparam int STS_IH  = 3;
  localparam int MMU_WR  = 0;
  localparam int MMU_DBL = 1;

  localparam logic [4:0] CODE_IRQ     = 5'd2;
  localparam logic [4:0] CODE_TRAP    = 5'd3;
  localparam logic [4:0] CODE_ILLEGAL = 5'd5;
  localparam logic [4:0] CODE_BREAK   = 5'd7;
  localparam logic [4:0] CODE_SUPV_I  = 5'd9;
  localparam logic [4:0] CODE_SUPV_D  = 5'd11;
  localparam logic [4:0] CODE_MISS    = 5'd12;
  localparam logic [4:0] CODE_PERM_R  = 5'd13;
  localparam logic [4:0] CODE_PERM_W  = 5'd14;
  localparam logic [4:0] CODE_PERM_X  = 5'd15;

  localparam logic [2:0] SEL_STATUS  = 3'd0;
  localparam logic [2:0] SEL_ESTATUS = 3'd1;
  localparam logic [2:0] SEL_BSTATUS = 3'd2;
  localparam logic [2:0] SEL_CAUSE   = 3'd3;
  localparam logic [2:0] SEL_MMUST   = 3'd4;

  typedef enum logic [2:0] {
    CL_NONE, CL_IRQ, CL_MISS, CL_PERM, CL_SOFT, CL_BREAK
  } exc_class_e;
endpackage

// File: rtl/exc_cause_decode.sv
module exc_cause_decode
  import exc_entry_pkg::*;
#(
  parameter int CAUSE_W = 5
) (
  input  logic [CAUSE_W-1:0] cause_i,
  output exc_class_e         cls_o,
  output logic               known_o
);
  always_comb begin
    unique case (5'(cause_i))
      CODE_TRAP, CODE_ILLEGAL, CODE_SUPV_I, CODE_SUPV_D: cls_o = CL_SOFT;
      CODE_BREAK:                                        cls_o = CL_BREAK;
      CODE_MISS:                                         cls_o = CL_MISS;
      CODE_PERM_R, CODE_PERM_W, CODE_PERM_X:             cls_o = CL_PERM;
      default:                                           cls_o = CL_NONE;
    endcase
    known_o = (cls_o != CL_NONE);
  end
endmodule

// File: rtl/exc_ctx_update.sv
module exc_ctx_update
  import exc_entry_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int CAUSE_W   = 5,
  parameter int CAUSE_LSB = 2,
  parameter int PC_STEP   = 4
) (
  input  exc_class_e         cls_i,
  input  logic [CAUSE_W-1:0] code_i,
  input  logic [DATA_W-1:0]  pc_i,
  input  logic [DATA_W-1:0]  gen_vec_i,
  input  logic [DATA_W-1:0]  miss_vec_i,
  input  logic [DATA_W-1:0]  status_q,
  input  logic [DATA_W-1:0]  estatus_q,
  input  logic [DATA_W-1:0]  bstatus_q,
  input  logic [DATA_W-1:0]  cause_q,
  input  logic [DATA_W-1:0]  mmust_q,
  input  logic [DATA_W-1:0]  ea_q,
  input  logic [DATA_W-1:0]  ba_q,
  input  logic [DATA_W-1:0]  pc_q,
  output logic [DATA_W-1:0]  status_d,
  output logic [DATA_W-1:0]  estatus_d,
  output logic [DATA_W-1:0]  bstatus_d,
  output logic [DATA_W-1:0]  cause_d,
  output logic [DATA_W-1:0]  mmust_d,
  output logic [DATA_W-1:0]  ea_d,
  output logic [DATA_W-1:0]  ba_d,
  output logic [DATA_W-1:0]  pc_d
);
  localparam logic [DATA_W-1:0] ONE        = DATA_W'(1);
  localparam logic [DATA_W-1:0] CAUSE_MASK =
    {{(DATA_W-CAUSE_W){1'b0}}, {CAUSE_W{1'b1}}} << CAUSE_LSB;
  localparam logic [DATA_W-1:0] DROP_MASK  = (ONE << STS_PIE) | (ONE << STS_U);

  logic [DATA_W-1:0] ret_addr;
  logic [DATA_W-1:0] sts_base;
  logic              in_handler;

  assign ret_addr   = pc_i + DATA_W'(PC_STEP);
  assign sts_base   = status_q & ~DROP_MASK;
  assign in_handler = status_q[STS_EH];

  always_comb begin
    status_d  = status_q;
    estatus_d = estatus_q;
    bstatus_d = bstatus_q;
    mmust_d   = mmust_q;
    ea_d      = ea_q;
    ba_d      = ba_q;
    pc_d      = pc_q;
    cause_d   = (cause_q & ~CAUSE_MASK) | ({{(DATA_W-CAUSE_W){1'b0}}, code_i} << CAUSE_LSB);
    unique case (cls_i)
      CL_IRQ: begin
        estatus_d = status_q;
        status_d  = sts_base | (ONE << STS_IH);
        ea_d      = ret_addr;
        pc_d      = gen_vec_i;
      end
      CL_MISS: begin
        status_d = sts_base | (ONE << STS_EH);
        if (!in_handler) begin
          estatus_d = status_q;
          mmust_d   = (mmust_q & ~(ONE << MMU_DBL)) | (ONE << MMU_WR);
          ea_d      = ret_addr;
          pc_d      = miss_vec_i;
        end else begin
          mmust_d = mmust_q | (ONE << MMU_DBL);
          pc_d    = gen_vec_i;
        end
      end
      CL_PERM: begin
        estatus_d = status_q;
        status_d  = sts_base | (ONE << STS_EH);
        ea_d      = ret_addr;
        pc_d      = gen_vec_i;
      end
      CL_SOFT: begin
        if (!in_handler) begin
          estatus_d = status_q;
          ea_d      = ret_addr;
        end
        status_d = sts_base | (ONE << STS_EH);
        pc_d     = gen_vec_i;
      end
      CL_BREAK: begin
        if (!in_handler) begin
          bstatus_d = status_q;
          ba_d      = ret_addr;
        end
        status_d = sts_base | (ONE << STS_EH);
        pc_d     = gen_vec_i;
      end
      default: cause_d = cause_q;
    endcase
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int CAUSE_W   = 5,
  parameter int CAUSE_LSB = 2,
  parameter int PC_STEP   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exc_req_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic               irq_i,
  input  logic [DATA_W-1:0]  pc_i,
  input  logic [DATA_W-1:0]  gen_vec_i,
  input  logic [DATA_W-1:0]  miss_vec_i,
  input  logic               ctl_wr_i,
  input  logic [2:0]         ctl_sel_i,
  input  logic [DATA_W-1:0]  ctl_wdata_i,
  output logic [DATA_W-1:0]  status_nx,
  output logic [DATA_W-1:0]  estatus_nx,
  output logic [DATA_W-1:0]  bstatus_nx,
  output logic [DATA_W-1:0]  cause_nx,
  output logic [DATA_W-1:0]  mmust_nx,
  output logic [DATA_W-1:0]  ea_nx,
  output logic [DATA_W-1:0]  ba_nx,
  output logic [DATA_W-1:0]  pc_nx,
  output logic [DATA_W-1:0]  status_q,
  output logic [DATA_W-1:0]  estatus_q,
  output logic [DATA_W-1:0]  bstatus_q,
  output logic [DATA_W-1:0]  cause_q,
  output logic [DATA_W-1:0]  mmust_q,
  output logic [DATA_W-1:0]  ea_q,
  output logic [DATA_W-1:0]  ba_q,
  output logic [DATA_W-1:0]  pc_q,
  output logic               abort_o
);
  localparam logic [CAUSE_W-1:0] IRQ_CODE = CAUSE_W'(CODE_IRQ);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  exc_class_e         dec_cls;
  logic               dec_known;
  exc_class_e         cls_eff;
  logic [CAUSE_W-1:0] code_eff;
  logic               take_sync, take_irq, wr_ok, abort_d, upd_en;

  exc_cause_decode #(.CAUSE_W(CAUSE_W)) u_decode (
    .cause_i (cause_i),
    .cls_o   (dec_cls),
    .known_o (dec_known)
  );

  // synchronous exception wins over the interrupt
  always_comb begin
    take_sync = exc_req_i && dec_known;
    take_irq  = !exc_req_i && irq_i && status_q[STS_PIE];
    abort_d   = exc_req_i && !dec_known;
    wr_ok     = ctl_wr_i && !exc_req_i && !take_irq;
    if (take_sync) begin
      cls_eff  = dec_cls;
      code_eff = cause_i;
    end else if (take_irq) begin
      cls_eff  = CL_IRQ;
      code_eff = IRQ_CODE;
    end else begin
      cls_eff  = CL_NONE;
      code_eff = cause_i;
    end
  end

  logic [DATA_W-1:0] st_u, est_u, bst_u, cau_u, mmu_u, ea_u, ba_u, pc_u;

  exc_ctx_update #(
    .DATA_W(DATA_W), .CAUSE_W(CAUSE_W), .CAUSE_LSB(CAUSE_LSB), .PC_STEP(PC_STEP)
  ) u_update (
    .cls_i      (cls_eff),
    .code_i     (code_eff),
    .pc_i       (pc_i),
    .gen_vec_i  (gen_vec_i),
    .miss_vec_i (miss_vec_i),
    .status_q   (status_q),
    .estatus_q  (estatus_q),
    .bstatus_q  (bstatus_q),
    .cause_q    (cause_q),
    .mmust_q    (mmust_q),
    .ea_q       (ea_q),
    .ba_q       (ba_q),
    .pc_q       (pc_q),
    .status_d   (st_u),
    .estatus_d  (est_u),
    .bstatus_d  (bst_u),
    .cause_d    (cau_u),
    .mmust_d    (mmu_u),
    .ea_d       (ea_u),
    .ba_d       (ba_u),
    .pc_d       (pc_u)
  );

  // next state: entry result, overlaid by an allowed control write
  always_comb begin
    status_nx  = st_u;
    estatus_nx = est_u;
    bstatus_nx = bst_u;
    cause_nx   = cau_u;
    mmust_nx   = mmu_u;
    ea_nx      = ea_u;
    ba_nx      = ba_u;
    pc_nx      = pc_u;
    if (wr_ok) begin
      unique case (ctl_sel_i)
        SEL_STATUS:  status_nx  = ctl_wdata_i;
        SEL_ESTATUS: estatus_nx = ctl_wdata_i;
        SEL_BSTATUS: bstatus_nx = ctl_wdata_i;
        SEL_CAUSE:   cause_nx   = ctl_wdata_i;
        SEL_MMUST:   mmust_nx   = ctl_wdata_i;
        default: ;
      endcase
    end
  end

  assign upd_en = take_sync || take_irq || wr_ok;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      status_q  <= '0;
      estatus_q <= '0;
      bstatus_q <= '0;
      cause_q   <= '0;
      mmust_q   <= '0;
      ea_q      <= '0;
      ba_q      <= '0;
      pc_q      <= '0;
      abort_o   <= 1'b0;
    end else begin
      abort_o <= abort_d;
      if (upd_en) begin
        status_q  <= status_nx;
        estatus_q <= estatus_nx;
        bstatus_q <= bstatus_nx;
        cause_q   <= cause_nx;
        mmust_q   <= mmust_nx;
        ea_q      <= ea_nx;
        ba_q      <= ba_nx;
        pc_q      <= pc_nx;
      end
    end
  end

  // R1: entry leaves PIE and U clear with a handler flag set
  a_r1_status_entry: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (take_sync || take_irq) |=> (!status_q[STS_PIE] && !status_q[STS_U] &&
                                 (status_q[STS_EH] || status_q[STS_IH])));
  // R2: bits outside the cause field survive an entry
  a_r2_cause_field: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (exc_req_i && dec_known) |=> (cause_q[CAUSE_LSB-1:0] == $past(cause_q[CAUSE_LSB-1:0]) &&
                                  cause_q[DATA_W-1:CAUSE_LSB+CAUSE_W] ==
                                  $past(cause_q[DATA_W-1:CAUSE_LSB+CAUSE_W])));
  // R3: interrupt held off while PIE is clear
  a_r3_irq_gated: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_i && !status_q[STS_PIE] && !exc_req_i && !ctl_wr_i) |=>
      (status_q == $past(status_q) && pc_q == $past(pc_q)));
  // R5: double miss keeps saved context and flags DBL
  a_r5_double_miss: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (exc_req_i && cause_i == CAUSE_W'(CODE_MISS) && status_q[STS_EH]) |=>
      (estatus_q == $past(estatus_q) && ea_q == $past(ea_q) && mmust_q[MMU_DBL]));
  // R9: synchronous cause beats a pending interrupt
  a_r9_sync_first: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (exc_req_i && dec_known && irq_i) |=>
      (cause_q[CAUSE_LSB+CAUSE_W-1:CAUSE_LSB] != IRQ_CODE && status_q[STS_EH]));
  // R10: unknown code aborts and freezes the registers
  a_r10_abort_freeze: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (exc_req_i && !dec_known) |=>
      (abort_o && status_q == $past(status_q) && pc_q == $past(pc_q) &&
       estatus_q == $past(estatus_q) && cause_q == $past(cause_q)));
  // R12: registers take the advertised next values on one edge
  a_r12_single_edge: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (take_sync || take_irq) |=> (pc_q == $past(pc_nx) && status_q == $past(status_nx)));
endmodule

// File: tb/test_exc_entry_ctrl.sv
module test_exc_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        exc_req_i, irq_i, ctl_wr_i;
  logic [4:0]  cause_i;
  logic [2:0]  ctl_sel_i;
  logic [31:0] pc_i, gen_vec_i, miss_vec_i, ctl_wdata_i;
  logic [31:0] status_nx, estatus_nx, bstatus_nx, cause_nx, mmust_nx, ea_nx, ba_nx, pc_nx;
  logic [31:0] status_q, estatus_q, bstatus_q, cause_q, mmust_q, ea_q, ba_q, pc_q;
  logic        abort_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  exc_entry_ctrl i_exc_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .exc_req_i(exc_req_i), .cause_i(cause_i), .irq_i(irq_i),
    .pc_i(pc_i), .gen_vec_i(gen_vec_i), .miss_vec_i(miss_vec_i),
    .ctl_wr_i(ctl_wr_i), .ctl_sel_i(ctl_sel_i), .ctl_wdata_i(ctl_wdata_i),
    .status_nx(status_nx), .estatus_nx(estatus_nx), .bstatus_nx(bstatus_nx),
    .cause_nx(cause_nx), .mmust_nx(mmust_nx), .ea_nx(ea_nx), .ba_nx(ba_nx), .pc_nx(pc_nx),
    .status_q(status_q), .estatus_q(estatus_q), .bstatus_q(bstatus_q), .cause_q(cause_q),
    .mmust_q(mmust_q), .ea_q(ea_q), .ba_q(ba_q), .pc_q(pc_q), .abort_o(abort_o)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // class: 0 unknown, 2 miss, 3 perm, 4 soft, 5 break
  function automatic int cls_of(int c);
    case (c)
      3, 5, 9, 11: return 4;
      7:           return 5;
      12:          return 2;
      13, 14, 15:  return 3;
      default:     return 0;
    endcase
  endfunction

  task automatic ctl_write(logic [2:0] sel, logic [31:0] val);
    @(negedge clk);
    ctl_wr_i = 1'b1; ctl_sel_i = sel; ctl_wdata_i = val;
    @(negedge clk);
    ctl_wr_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] m_st, m_est, m_bst, m_cau, m_mmu, m_ea, m_ba, m_pc;
    logic [31:0] e_st, e_est, e_bst, e_cau, e_mmu, e_ea, e_ba, e_pc;
    logic [31:0] junk, ret;
    logic        e_abort;
    rst_n = 1'b0; exc_req_i = 0; irq_i = 0; ctl_wr_i = 0; cause_i = 0; ctl_sel_i = 0;
    pc_i = 0; gen_vec_i = 32'h0000_0020; miss_vec_i = 32'h0000_0040; ctl_wdata_i = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R12: reset state
    chk("R12", "reset status", status_q, 0);
    chk("R12", "reset pc", pc_q, 0);
    chk("R12", "reset ea", ea_q, 0);
    chk("R12", "reset abort", {31'd0, abort_o}, 0);
    m_ea = 0; m_ba = 0; m_pc = 0;
    for (int c = 0; c <= 32; c++) begin
      for (int eh = 0; eh < 2; eh++) begin
        for (int pie = 0; pie < 2; pie++) begin
          for (int irq = 0; irq < 2; irq++) begin
            automatic int  k = ((c * 2 + eh) * 2 + pie) * 2 + irq;
            automatic bit  sync = (c < 32);
            automatic int  cl = sync ? cls_of(c) : 0;
            automatic bit  irq_acc = !sync && irq == 1 && pie == 1;
            automatic string rq;
            m_st  = 32'h0000_0032 | (pie ? 32'h1 : 0) | (eh ? 32'h4 : 0);
            m_est = 32'h1111_0000 + k;
            m_bst = 32'h2222_0000 + k;
            m_cau = 32'hA5A5_A503;
            m_mmu = (k % 2) ? 32'h00F0_0002 : 32'h00F0_0001;
            ctl_write(3'd0, m_st);
            ctl_write(3'd1, m_est);
            ctl_write(3'd2, m_bst);
            ctl_write(3'd3, m_cau);
            ctl_write(3'd4, m_mmu);
            // R11: write to estatus in the same cycle as the event
            junk = 32'hDEAD_0000 + k;
            pc_i = 32'h0001_0000 + k * 16;
            gen_vec_i = 32'h0000_0100 + k * 4;
            miss_vec_i = 32'h0000_8000 + k * 8;
            ret = pc_i + 4;
            e_st = m_st; e_est = m_est; e_bst = m_bst; e_cau = m_cau;
            e_mmu = m_mmu; e_ea = m_ea; e_ba = m_ba; e_pc = m_pc;
            e_abort = sync && cl == 0;
            rq = "R11";
            if (irq_acc) begin
              rq = "R3";
              e_est = m_st; e_st = (m_st & ~32'h3) | 32'h8;
              e_ea = ret; e_pc = gen_vec_i;
              e_cau = (m_cau & ~32'h7C) | (32'd2 << 2);
            end else if (sync && cl != 0) begin
              e_st  = (m_st & ~32'h3) | 32'h4;
              e_cau = (m_cau & ~32'h7C) | (32'(c) << 2);
              e_pc  = gen_vec_i;
              case (cl)
                2: if (eh == 0) begin
                     rq = "R4"; e_est = m_st; e_mmu = (m_mmu & ~32'h2) | 32'h1;
                     e_ea = ret; e_pc = miss_vec_i;
                   end else begin
                     rq = "R5"; e_mmu = m_mmu | 32'h2;
                   end
                3: begin rq = "R6"; e_est = m_st; e_ea = ret; end
                4: begin rq = "R7"; if (eh == 0) begin e_est = m_st; e_ea = ret; end end
                default: begin rq = "R8"; if (eh == 0) begin e_bst = m_st; e_ba = ret; end end
              endcase
              if (irq == 1) rq = "R9";
            end else if (sync) begin
              rq = "R10";
            end
            if (!sync && !irq_acc) e_est = junk;
            @(negedge clk);
            exc_req_i = sync; cause_i = 5'(c); irq_i = irq[0];
            ctl_wr_i = 1'b1; ctl_sel_i = 3'd1; ctl_wdata_i = junk;
            #1;
            chk("R12", "status_nx", status_nx, e_st);
            chk("R12", "pc_nx", pc_nx, e_pc);
            @(negedge clk);
            exc_req_i = 0; irq_i = 0; ctl_wr_i = 0;
            chk("R1", "status", status_q, e_st);
            chk("R2", "cause", cause_q, e_cau);
            chk(rq, "estatus", estatus_q, e_est);
            chk(rq, "bstatus", bstatus_q, e_bst);
            chk(rq, "mmust", mmust_q, e_mmu);
            chk(rq, "ea", ea_q, e_ea);
            chk(rq, "ba", ba_q, e_ba);
            chk(rq, "pc", pc_q, e_pc);
            chk("R10", "abort", {31'd0, abort_o}, {31'd0, e_abort});
            m_ea = e_ea; m_ba = e_ba; m_pc = e_pc;
          end
        end
      end
    end
    @(negedge clk);
    chk("R10", "abort one cycle", {31'd0, abort_o}, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule